// File: doc/BRIEF.md
# Packet-Granular Ingress Staging Buffer

This block is an on-chip staging store placed in front of a slow external memory path that cannot take data in real time. Payload bytes of 192-byte transport-stream packets arrive one per cycle on a valid/ready port. Each packet carries a 9-bit channel number, which is sampled with its first byte. A packet's bytes are counted into a fixed slot. A slot becomes visible to the downstream arbiter only when all 192 bytes are present.

While a complete packet is waiting and no burst is under way, the block raises a request. One grant cycle from the arbiter starts a burst. The burst moves the oldest stored packet out as 192 back-to-back bytes with first and last markers and the packet's channel number. When the burst ends, the slot goes back to the free pool. Four slots form a circular queue, so packets leave in the order in which they finished arriving.

Top module: `pkt_stage_buf`

## Requirements
- R1: `in_ready_o` is high exactly when fewer than 4 complete packets are stored. A byte is taken only on a cycle where `in_valid_i` and `in_ready_o` are both high. Bytes offered while ready is low are dropped and do not shift the data of later packets.
- R2: The channel number applied on byte 0 of a packet is the value on `out_chan_o` for every byte of that packet's burst. `in_chan_i` on bytes 1..191 has no effect.
- R3: `req_o` is high when at least one complete packet is stored and no burst is running. It stays low while only part of a packet has arrived.
- R4: A clock edge with `gnt_i` and `req_o` both high starts a burst. From the next cycle, `out_valid_o` stays high for exactly 192 consecutive cycles. `out_first_o` is high only on byte 0 and `out_last_o` only on byte 191.
- R5: `gnt_i` has no effect while `req_o` is low, whether the buffer is empty or a burst is running.
- R6: Packets leave in the order they completed. Each packet's bytes come out unchanged and in arrival order.
- R7: A packet's slot is freed at the edge that ends its burst. If the buffer was full, `in_ready_o` is high in the cycle after the last byte.
- R8: When a packet completes at the same edge that ends a burst, the stored-packet count stays the same. Every remaining packet is offered exactly once afterwards.
- R9: After reset, `in_ready_o` is 1 and `req_o` and `out_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Ingress byte valid |
| in_ready_o | output | 1 | Ingress can take a byte |
| in_data_i | input | 8 | Ingress payload byte |
| in_chan_i | input | 9 | Channel number, sampled on byte 0 of a packet |
| req_o | output | 1 | A complete packet is waiting for a grant |
| gnt_i | input | 1 | Write-allow grant from the arbiter |
| out_valid_o | output | 1 | Burst byte valid |
| out_first_o | output | 1 | Byte 0 of a burst |
| out_last_o | output | 1 | Byte 191 of a burst |
| out_data_o | output | 8 | Burst payload byte |
| out_chan_o | output | 9 | Channel number of the packet being sent |

## Verification
- Byte 0 of a burst is due one cycle after the grant edge, and byte k is due k cycles after that. `req_o` rises one cycle after the edge that accepts byte 191 of a packet. `in_ready_o` recovers one cycle after the `out_last_o` cycle.
- The bench drives inputs and samples outputs on the falling edge. Each timed check is placed on the falling edge that follows the responsible rising edge.
- A scoreboard pops one expected byte, with its channel and markers, for every valid output cycle. A timed case makes a packet complete on exactly the edge that releases a slot.

// File: rtl/pkt_stage_pkg.sv
package pkt_stage_pkg;
  localparam int unsigned DEF_PKT_BYTES = 192;
  localparam int unsigned DEF_SLOTS     = 4;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_CH_W      = 9;

  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pkt_slot_ring.sv
module pkt_slot_ring
  import pkt_stage_pkg::*;
#(
  parameter int unsigned SLOTS  = DEF_SLOTS,
  localparam int unsigned SLOT_W = idx_w(SLOTS),
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              release_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [SLOT_W-1:0] rd_slot_o
);
  logic [CNT_W-1:0]  count_q;
  logic [SLOT_W-1:0] wr_q, rd_q;

  function automatic logic [SLOT_W-1:0] bump(logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      // net change keeps the count exact when both happen together
      count_q <= count_q + CNT_W'(commit_i) - CNT_W'(release_i);
      if (commit_i)  wr_q <= bump(wr_q);
      if (release_i) rd_q <= bump(rd_q);
    end
  end

  assign full_o    = (count_q == CNT_W'(SLOTS));
  assign empty_o   = (count_q == '0);
  assign wr_slot_o = wr_q;
  assign rd_slot_o = rd_q;

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(SLOTS));
  p_no_commit_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !commit_i);
  p_no_release_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !release_i);
  p_count_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && release_i) |=> $stable(count_q));
endmodule

// File: rtl/pkt_ingress.sv
module pkt_ingress
  import pkt_stage_pkg::*;
#(
  parameter int unsigned PKT_BYTES = DEF_PKT_BYTES,
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned CH_W      = DEF_CH_W,
  localparam int unsigned SLOT_W   = idx_w(SLOTS),
  localparam int unsigned OFF_W    = idx_w(PKT_BYTES),
  localparam int unsigned ADDR_W   = idx_w(SLOTS * PKT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              full_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              cwe_o,
  output logic [CH_W-1:0]   cdata_o,
  output logic              commit_o
);
  logic [OFF_W-1:0] off_q;
  logic             accept, at_end;

  assign ready_o  = !full_i;
  assign accept   = valid_i && ready_o;
  assign at_end   = (off_q == OFF_W'(PKT_BYTES - 1));
  assign we_o     = accept;
  assign waddr_o  = ADDR_W'(slot_i) * ADDR_W'(PKT_BYTES) + ADDR_W'(off_q);
  assign wdata_o  = data_i;
  assign cwe_o    = accept && (off_q == '0);
  assign cdata_o  = chan_i;
  assign commit_o = accept && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (accept) off_q <= at_end ? '0 : off_q + 1'b1;
  end

  p_hold_when_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_i) |=> $stable(off_q));
endmodule

// File: rtl/pkt_store.sv
module pkt_store
  import pkt_stage_pkg::*;
#(
  parameter int unsigned PKT_BYTES = DEF_PKT_BYTES,
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned CH_W      = DEF_CH_W,
  localparam int unsigned SLOT_W   = idx_w(SLOTS),
  localparam int unsigned DEPTH    = SLOTS * PKT_BYTES,
  localparam int unsigned ADDR_W   = idx_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cwe_i,
  input  logic [SLOT_W-1:0] cslot_w_i,
  input  logic [CH_W-1:0]   cdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SLOT_W-1:0] cslot_r_i,
  output logic [CH_W-1:0]   cdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CH_W-1:0]   chan_q [SLOTS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 chan_q[s] <= '0;
      else if (cwe_i && cslot_w_i == SLOT_W'(s))   chan_q[s] <= cdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
  assign cdata_o = chan_q[cslot_r_i];
endmodule

// File: rtl/pkt_burst_out.sv
module pkt_burst_out
  import pkt_stage_pkg::*;
#(
  parameter int unsigned PKT_BYTES = DEF_PKT_BYTES,
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned CH_W      = DEF_CH_W,
  localparam int unsigned SLOT_W   = idx_w(SLOTS),
  localparam int unsigned OFF_W    = idx_w(PKT_BYTES),
  localparam int unsigned ADDR_W   = idx_w(SLOTS * PKT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  logic              gnt_i,
  output logic              req_o,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [CH_W-1:0]   rchan_i,
  output logic              release_o,
  output logic              valid_o,
  output logic              first_o,
  output logic              last_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CH_W-1:0]   chan_o
);
  logic [OFF_W-1:0] off_q;
  logic             start;

  assign req_o     = !empty_i && !valid_o;
  assign start     = gnt_i && req_o;
  assign raddr_o   = ADDR_W'(slot_i) * ADDR_W'(PKT_BYTES)
                   + (valid_o ? ADDR_W'(off_q) : '0);
  assign release_o = valid_o && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
      chan_o  <= '0;
      off_q   <= '0;
    end else if (start) begin
      valid_o <= 1'b1;
      first_o <= 1'b1;
      last_o  <= (PKT_BYTES == 1);
      data_o  <= rdata_i;
      chan_o  <= rchan_i;
      off_q   <= OFF_W'(1);
    end else if (valid_o) begin
      if (last_o) begin
        valid_o <= 1'b0;
        first_o <= 1'b0;
        last_o  <= 1'b0;
      end else begin
        first_o <= 1'b0;
        last_o  <= (off_q == OFF_W'(PKT_BYTES - 1));
        data_o  <= rdata_i;
        off_q   <= off_q + 1'b1;
      end
    end
  end

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && req_o) |=> (valid_o && first_o));
  p_contig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);
  p_marks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({first_o, last_o}));
  p_chan_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !first_o) |-> $stable(chan_o));
  p_gnt_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && empty_i && !valid_o) |=> !valid_o);
endmodule

// File: rtl/pkt_stage_buf.sv
module pkt_stage_buf
  import pkt_stage_pkg::*;
#(
  parameter int unsigned PKT_BYTES = DEF_PKT_BYTES,
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned CH_W      = DEF_CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [CH_W-1:0]   in_chan_i,
  output logic              req_o,
  input  logic              gnt_i,
  output logic              out_valid_o,
  output logic              out_first_o,
  output logic              out_last_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [CH_W-1:0]   out_chan_o
);
  localparam int unsigned SLOT_W = idx_w(SLOTS);
  localparam int unsigned ADDR_W = idx_w(SLOTS * PKT_BYTES);

  logic              full, empty, commit, release_s, we, cwe;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;
  logic [CH_W-1:0]   cwdata, crdata;

  pkt_slot_ring #(.SLOTS(SLOTS)) u_ring (
    .clk_i, .rst_ni,
    .commit_i(commit), .release_i(release_s),
    .full_o(full), .empty_o(empty),
    .wr_slot_o(wr_slot), .rd_slot_o(rd_slot)
  );

  pkt_ingress #(.PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS), .DATA_W(DATA_W), .CH_W(CH_W)) u_in (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .ready_o(in_ready_o),
    .data_i(in_data_i), .chan_i(in_chan_i),
    .full_i(full), .slot_i(wr_slot),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .cwe_o(cwe), .cdata_o(cwdata), .commit_o(commit)
  );

  pkt_store #(.PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS), .DATA_W(DATA_W), .CH_W(CH_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .cwe_i(cwe), .cslot_w_i(wr_slot), .cdata_i(cwdata),
    .raddr_i(raddr), .rdata_o(rdata),
    .cslot_r_i(rd_slot), .cdata_o(crdata)
  );

  pkt_burst_out #(.PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS), .DATA_W(DATA_W), .CH_W(CH_W)) u_out (
    .clk_i, .rst_ni,
    .empty_i(empty), .gnt_i(gnt_i), .req_o(req_o),
    .slot_i(rd_slot), .raddr_o(raddr),
    .rdata_i(rdata), .rchan_i(crdata),
    .release_o(release_s),
    .valid_o(out_valid_o), .first_o(out_first_o), .last_o(out_last_o),
    .data_o(out_data_o), .chan_o(out_chan_o)
  );

  p_partial_hidden_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !commit) |=> (req_o || out_valid_o || release_s));
endmodule

// File: tb/sim_pkt_stage_buf.sv
module sim_pkt_stage_buf;
  typedef struct packed {
    logic [8:0] chan;
    logic [7:0] data;
    logic       first;
    logic       last;
  } beat_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [8:0] in_chan = '0;
  logic       gnt = 1'b0;
  logic       auto_gnt = 1'b0;
  logic       in_ready, req, out_valid, out_first, out_last;
  logic [7:0] out_data;
  logic [8:0] out_chan;

  int checks = 0;
  int fails  = 0;
  beat_t exp_q[$];
  logic prev_valid = 1'b0, prev_last = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  pkt_stage_buf u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_chan_i(in_chan),
    .req_o(req), .gnt_i(gnt),
    .out_valid_o(out_valid), .out_first_o(out_first), .out_last_o(out_last),
    .out_data_o(out_data), .out_chan_o(out_chan)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat(int ch, int i);
    return 8'(ch * 7 + i * 13 + 3);
  endfunction

  // driver: bytes lo..hi of a packet; in_chan carries junk after byte 0 (R2)
  task automatic send_bytes(input int ch, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(ch, i);
      in_chan  = (i == 0) ? 9'(ch) : 9'(ch ^ (i * 37));
      while (!in_ready) @(negedge clk);
      exp_q.push_back('{chan: 9'(ch), data: pat(ch, i), first: (i == 0), last: (i == 191)});
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic grant_one();
    @(negedge clk); gnt = 1'b1;
    @(negedge clk); gnt = 1'b0;
    while (!out_last) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) if (auto_gnt) gnt = req;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid && !prev_last)
        chk(out_valid, "R4 valid gap", out_valid, 1);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5/R6 unexpected byte", out_data, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(out_data == e.data, "R6 data", out_data, e.data);
          chk(out_chan == e.chan, "R2 chan", out_chan, e.chan);
          chk(out_first == e.first, "R4 first", out_first, e.first);
          chk(out_last == e.last, "R4 last", out_last, e.last);
        end
      end
      prev_valid = out_valid;
      prev_last  = out_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready", in_ready, 1);
    chk(req == 1'b0, "R9 req", req, 0);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);

    // R5: grant on empty buffer
    gnt = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 grant while empty", out_valid, 0);
    end
    gnt = 1'b0;

    // R3: partial packet never offered
    send_bytes(9'h1A5, 0, 99);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(req == 1'b0, "R3 partial offered", req, 0);
    end
    send_bytes(9'h1A5, 100, 191);
    chk(req == 1'b1, "R3 req after complete", req, 1);

    // R1: fill to four slots
    send_bytes(9'h002, 0, 191);
    send_bytes(9'h1FF, 0, 191);
    send_bytes(9'h080, 0, 191);
    chk(in_ready == 1'b0, "R1 ready when full", in_ready, 0);
    in_valid = 1'b1; in_data = 8'hEE; in_chan = 9'h155;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R1 ready held low", in_ready, 0);
    end
    in_valid = 1'b0;

    // R4/R5: grant held three cycles starts exactly one burst
    @(negedge clk); gnt = 1'b1;
    @(negedge clk);
    chk(out_valid && out_first, "R4 burst start", {out_valid, out_first}, 3);
    chk(req == 1'b0, "R3 req low in burst", req, 0);
    @(negedge clk);
    @(negedge clk); gnt = 1'b0;
    while (!out_last) @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 slot freed", in_ready, 1);
    chk(out_valid == 1'b0, "R4 burst ended", out_valid, 0);

    // R8: packet completes on the edge that ends a burst
    grant_one();
    send_bytes(9'h0C3, 0, 190);
    @(negedge clk); gnt = 1'b1;
    @(negedge clk); gnt = 1'b0;
    while (!out_last) @(negedge clk);
    in_valid = 1'b1; in_data = pat(9'h0C3, 191); in_chan = 9'h000;
    chk(in_ready == 1'b1, "R8 ready at collision", in_ready, 1);
    exp_q.push_back('{chan: 9'h0C3, data: pat(9'h0C3, 191), first: 1'b0, last: 1'b1});
    @(negedge clk); in_valid = 1'b0;
    chk(req == 1'b1, "R8 req after collision", req, 1);
    grant_one();
    chk(req == 1'b1, "R8 one packet left", req, 1);
    grant_one();
    chk(req == 1'b0, "R8 count drained", req, 0);
    chk(exp_q.size() == 0, "R6 queue after drain", exp_q.size(), 0);

    // R6: streaming with automatic grants
    auto_gnt = 1'b1;
    for (int p = 0; p < 6; p++) send_bytes(p * 71 + 5, 0, 191);
    for (int k = 0; k < 2000 && (exp_q.size() != 0 || out_valid); k++) @(negedge clk);
    auto_gnt = 1'b0;
    @(negedge clk); gnt = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all packets out", exp_q.size(), 0);
    chk(req == 1'b0 && in_ready == 1'b1, "R9 idle at end", {req, in_ready}, 1);
    summary();
  end
endmodule